// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clocks of a processor clock domain keep running while the core sleeps. When the core signals an idle request, a two-bit mode field picks one of three sleep depths. The lightest depth leaves every clock running. The middle depth stops the core and system clocks but keeps the oscillator alive, so the watchdog still works. The deepest depth also turns off the oscillator and PLL. Each depth has its own set of events that can end it.

For the middle depth, software chooses the wake lines through a mask. A chosen line has to stay low for a programmable number of oscillator cycles. A shorter low pulse is thrown away, and the block stays asleep. When a wake is accepted, the block turns the clocks back on one at a time, starting at the oscillator, then the core clock, then the system clock. It then gives the core a single-cycle wake pulse and stays in normal mode until the next idle request.

The block is clocked by the free-running oscillator clock. Its synchronous reset acts as the reset wake source in every state.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to normal mode from any state, with `osc_en`, `core_clk_en` and `sysclk_en` at 1, `wake_pulse` at 0 and the qualification count cleared.
- R2: In normal mode with `idle_req` low, `lpm_mode` and every wake line have no effect, and all three clock enables stay at 1.
- R3: An idle request with `lpm_mode` = 2'b00 enters the light sleep state and leaves all three enables at 1.
- R4: An idle request with `lpm_mode` = 2'b01 enters standby. From the next edge, `osc_en` is 1 and `core_clk_en` and `sysclk_en` are 0.
- R5: An idle request with `lpm_mode[1]` = 1, whatever `lpm_mode[0]` is, enters halt. From the next edge, all three enables are 0.
- R6: In light sleep, a low `wdint_n`, a low `nmi_n` or a high `irq_pending` sampled at an edge is accepted as a wake at that edge. A low peripheral line is ignored.
- R7: In halt, only a low `nmi_n` is accepted as a wake. `wdint_n`, `irq_pending` and the peripheral lines are ignored.
- R8: In standby, a low `wdint_n` is accepted at once, without qualification and regardless of the mask.
- R9: In standby, the wake lines are `wake_mask` bit 0 = `nmi_n` and bit k+1 = `periph_wake_n[k]`. A wake is accepted at the (`qual_len`+2)-th consecutive edge at which at least one selected line is low. A line whose mask bit is 0 is ignored.
- R10: If all selected lines are high at an edge before that count is reached, the count restarts and the block stays in standby.
- R11: After the accepting edge A, the enables come back in this order: `osc_en` at A, `core_clk_en` at A+1, `sysclk_en` at A+2. `wake_pulse` is high for exactly the one cycle after edge A+3.
- R12: After a wake, the block stays in normal mode with all enables at 1 until `idle_req` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset, also the reset wake source |
| idle_req | input | 1 | Core idle request |
| lpm_mode | input | 2 | Sleep depth select |
| wake_mask | input | NUM_PERIPH+1 | Standby wake select, bit 0 NMI, bit k+1 peripheral line k |
| qual_len | input | QUAL_W | Standby qualification length minus 2 |
| nmi_n | input | 1 | Non-maskable interrupt line, active low |
| wdint_n | input | 1 | Watchdog interrupt, active low |
| periph_wake_n | input | NUM_PERIPH | Peripheral, trip and receive wake lines, active low |
| irq_pending | input | 1 | An enabled interrupt is pending |
| osc_en | output | 1 | Oscillator and PLL enable |
| core_clk_en | output | 1 | Core input clock enable |
| sysclk_en | output | 1 | System clock output enable |
| wake_pulse | output | 1 | One-cycle wake indication to the core |

## Verification
Every output is a register, so an idle request sampled at an edge shows its gating effect right after that edge. Immediate wakes show `osc_en` at the sampling edge, `core_clk_en` one edge later, `sysclk_en` two edges later, and `wake_pulse` three edges later. A qualified standby wake lands on the (`qual_len`+2)-th edge at which the line is held low. The bench changes inputs only on falling edges and reads outputs on the next falling edge. It therefore counts exactly one rising edge per step, and it checks the outputs at every step of a hold. This shows that one step short of the count gives nothing, and that the full count gives the restore sequence on the expected edges.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    S_NORMAL,
    S_IDLE,
    S_STANDBY,
    S_HALT,
    S_RCORE,
    S_RSYS,
    S_RPULSE
  } lpm_state_t;

  typedef enum logic [1:0] {
    M_IDLE,
    M_STANDBY,
    M_HALT
  } lpm_sel_t;

  // bit 1 set selects the deepest state whatever bit 0 holds
  function automatic lpm_sel_t decode_mode(input logic [1:0] m);
    if (m[1])      return M_HALT;
    else if (m[0]) return M_STANDBY;
    else           return M_IDLE;
  endfunction

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int NUM_PERIPH = 8,
  parameter int QUAL_W     = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  active,
  input  logic                  nmi_n,
  input  logic [NUM_PERIPH-1:0] periph_wake_n,
  input  logic [NUM_PERIPH:0]   wake_mask,
  input  logic [QUAL_W-1:0]     qual_len,
  output logic                  accept
);
  localparam int MASK_W = NUM_PERIPH + 1;
  localparam int CNT_W  = QUAL_W + 1;

  logic [MASK_W-1:0] lines;
  logic [MASK_W-1:0] sel_low;
  logic              sel_all_high;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  target;

  assign lines = {periph_wake_n, nmi_n};

  for (genvar i = 0; i < MASK_W; i++) begin : g_sel
    assign sel_low[i] = wake_mask[i] & ~lines[i];
  end

  assign sel_all_high = ~|sel_low;
  assign target       = {1'b0, qual_len} + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !active || sel_all_high) cnt <= '0;
    else if (cnt != target)              cnt <= cnt + CNT_W'(1);
  end

  assign accept = active && !sel_all_high && (cnt == target);

  // R10: a release of every selected line restarts the count
  p_qual_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (active && sel_all_high) |=> (cnt == '0));

  // R9: acceptance only while a selected line is held low
  p_accept_low_r9: assert property (@(posedge clk) disable iff (rst)
    accept |-> (|(wake_mask & ~lines)));

  // R9: the count never runs past its target
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt <= target) || !$stable(qual_len) || $past(rst));

endmodule

// File: rtl/lpm_wake_decode.sv
module lpm_wake_decode
  import lpm_pkg::*;
(
  input  lpm_state_t st,
  input  logic       nmi_n,
  input  logic       wdint_n,
  input  logic       irq_pending,
  input  logic       qual_accept,
  output logic       wake
);
  always_comb begin
    unique case (st)
      S_IDLE:    wake = !wdint_n || !nmi_n || irq_pending;
      S_STANDBY: wake = !wdint_n || qual_accept;
      S_HALT:    wake = !nmi_n;
      default:   wake = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpm_clk_seq.sv
module lpm_clk_seq
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idle_req,
  input  logic [1:0] lpm_mode,
  input  logic       wake,
  output lpm_state_t st,
  output logic       osc_en,
  output logic       core_clk_en,
  output logic       sysclk_en,
  output logic       wake_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_NORMAL;
      osc_en      <= 1'b1;
      core_clk_en <= 1'b1;
      sysclk_en   <= 1'b1;
      wake_pulse  <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      unique case (st)
        S_NORMAL: begin
          if (idle_req) begin
            unique case (decode_mode(lpm_mode))
              M_IDLE: st <= S_IDLE;
              M_STANDBY: begin
                st          <= S_STANDBY;
                core_clk_en <= 1'b0;
                sysclk_en   <= 1'b0;
              end
              default: begin
                st          <= S_HALT;
                osc_en      <= 1'b0;
                core_clk_en <= 1'b0;
                sysclk_en   <= 1'b0;
              end
            endcase
          end
        end
        S_IDLE, S_STANDBY, S_HALT: begin
          if (wake) begin
            osc_en <= 1'b1;
            st     <= S_RCORE;
          end
        end
        S_RCORE: begin
          core_clk_en <= 1'b1;
          st          <= S_RSYS;
        end
        S_RSYS: begin
          sysclk_en <= 1'b1;
          st        <= S_RPULSE;
        end
        S_RPULSE: begin
          wake_pulse <= 1'b1;
          st         <= S_NORMAL;
        end
        default: st <= S_NORMAL;
      endcase
    end
  end

  // R3: light sleep keeps every clock running
  p_idle_clocks_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> (osc_en && core_clk_en && sysclk_en));

  // R4: standby keeps only the oscillator
  p_standby_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_STANDBY) |-> (osc_en && !core_clk_en && !sysclk_en));

  // R5: halt stops everything
  p_halt_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_HALT) |-> (!osc_en && !core_clk_en && !sysclk_en));

  // R11: core clock returns only after the oscillator
  p_core_after_osc_r11: assert property (@(posedge clk) disable iff (rst)
    ($rose(core_clk_en) && !$past(rst)) |-> $past(osc_en));

  // R11: system clock returns only after the core clock
  p_sys_after_core_r11: assert property (@(posedge clk) disable iff (rst)
    ($rose(sysclk_en) && !$past(rst)) |-> $past(core_clk_en));

  // R11: the wake pulse lasts one cycle
  p_pulse_single_r11: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  // R12: normal mode holds until an idle request
  p_normal_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (st == S_NORMAL && !idle_req) |=> (st == S_NORMAL && osc_en && core_clk_en && sysclk_en));

endmodule

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int QUAL_W     = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  idle_req,
  input  logic [1:0]            lpm_mode,
  input  logic [NUM_PERIPH:0]   wake_mask,
  input  logic [QUAL_W-1:0]     qual_len,
  input  logic                  nmi_n,
  input  logic                  wdint_n,
  input  logic [NUM_PERIPH-1:0] periph_wake_n,
  input  logic                  irq_pending,
  output logic                  osc_en,
  output logic                  core_clk_en,
  output logic                  sysclk_en,
  output logic                  wake_pulse
);
  lpm_state_t st;
  logic       qual_accept;
  logic       wake;
  logic       in_standby;

  assign in_standby = (st == S_STANDBY);

  lpm_wake_qual #(
    .NUM_PERIPH (NUM_PERIPH),
    .QUAL_W     (QUAL_W)
  ) u_qual (
    .clk           (clk),
    .rst           (rst),
    .active        (in_standby),
    .nmi_n         (nmi_n),
    .periph_wake_n (periph_wake_n),
    .wake_mask     (wake_mask),
    .qual_len      (qual_len),
    .accept        (qual_accept)
  );

  lpm_wake_decode u_dec (
    .st          (st),
    .nmi_n       (nmi_n),
    .wdint_n     (wdint_n),
    .irq_pending (irq_pending),
    .qual_accept (qual_accept),
    .wake        (wake)
  );

  lpm_clk_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .idle_req    (idle_req),
    .lpm_mode    (lpm_mode),
    .wake        (wake),
    .st          (st),
    .osc_en      (osc_en),
    .core_clk_en (core_clk_en),
    .sysclk_en   (sysclk_en),
    .wake_pulse  (wake_pulse)
  );

  // R7: halt is left only through the NMI line
  p_halt_nmi_only_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_HALT && nmi_n) |=> (st == S_HALT));

  // R1: reset always lands in normal mode with clocks on
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (st == S_NORMAL && osc_en && core_clk_en && sysclk_en && !wake_pulse));

endmodule

// File: tb/lpm_clock_ctrl_bench.sv
module lpm_clock_ctrl_bench;
  localparam int NP = 8;
  localparam int QW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          idle_req = 1'b0;
  logic [1:0]    lpm_mode = 2'b00;
  logic [NP:0]   wake_mask = '0;
  logic [QW-1:0] qual_len = '0;
  logic          nmi_n = 1'b1;
  logic          wdint_n = 1'b1;
  logic [NP-1:0] periph_wake_n = '1;
  logic          irq_pending = 1'b0;
  logic          osc_en, core_clk_en, sysclk_en, wake_pulse;

  int vectors = 0;
  int misses  = 0;

  always #4 clk = ~clk;

  lpm_clock_ctrl #(.NUM_PERIPH(NP), .QUAL_W(QW)) u_lpm_clock_ctrl (
    .clk (clk), .rst (rst), .idle_req (idle_req), .lpm_mode (lpm_mode),
    .wake_mask (wake_mask), .qual_len (qual_len), .nmi_n (nmi_n),
    .wdint_n (wdint_n), .periph_wake_n (periph_wake_n), .irq_pending (irq_pending),
    .osc_en (osc_en), .core_clk_en (core_clk_en), .sysclk_en (sysclk_en),
    .wake_pulse (wake_pulse)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input logic eo, ec, es, ep, input string req);
    vectors++;
    if ({osc_en, core_clk_en, sysclk_en, wake_pulse} !== {eo, ec, es, ep}) begin
      misses++;
      $display("FAIL %s: got osc/core/sys/pulse=%b%b%b%b expected %b%b%b%b",
               req, osc_en, core_clk_en, sysclk_en, wake_pulse, eo, ec, es, ep);
    end
  endtask

  // gating expected inside sleep state m
  task automatic check_sleep(input int m, input string req);
    if (m == 0)      check(1, 1, 1, 0, req);
    else if (m == 1) check(1, 0, 0, 0, req);
    else             check(0, 0, 0, 0, req);
  endtask

  task automatic enter(input int m);
    idle_req = 1'b1;
    lpm_mode = 2'(m);
    step();
    idle_req = 1'b0;
    lpm_mode = 2'(3 - m);
    if (m == 0)      check_sleep(m, "R3");
    else if (m == 1) check_sleep(m, "R4");
    else             check_sleep(m, "R5");
  endtask

  // called at the falling edge right after the accepting edge
  task automatic restore(input int m);
    check(1, m == 0, m == 0, 0, "R11 osc first");
    step(); check(1, 1, m == 0, 0, "R11 core second");
    step(); check(1, 1, 1, 0, "R11 sys third");
    step(); check(1, 1, 1, 1, "R11 pulse");
    step(); check(1, 1, 1, 0, "R11 pulse single");
    nmi_n = 1'b1; wdint_n = 1'b1; irq_pending = 1'b0; periph_wake_n = '1;
    for (int k = 0; k < 3; k++) begin
      step(); check(1, 1, 1, 0, "R12 stays normal");
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    check(1, 1, 1, 0, "R1 reset");
  endtask

  // drive one standby line (idx 0 = NMI, idx k+1 = periph k) low or high
  task automatic drive_line(input int idx, input logic v);
    if (idx == 0) nmi_n = v;
    else          periph_wake_n[idx-1] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    step();
    do_reset();

    // R2: mode field and wake lines do nothing without an idle request
    for (int m = 0; m < 4; m++) begin
      lpm_mode = 2'(m); wdint_n = 1'b0; nmi_n = 1'b0; irq_pending = 1'b1;
      step(); check(1, 1, 1, 0, "R2 normal ignores mode");
    end
    wdint_n = 1'b1; nmi_n = 1'b1; irq_pending = 1'b0;

    // R6: light sleep wakes on each of three sources, ignores peripheral lines
    for (int s = 0; s < 3; s++) begin
      enter(0);
      periph_wake_n = '0; wake_mask = '1;
      for (int k = 0; k < 3; k++) begin step(); check_sleep(0, "R6 periph ignored"); end
      periph_wake_n = '1;
      step(); check_sleep(0, "R6 no wake");
      if (s == 0) wdint_n = 1'b0; else if (s == 1) nmi_n = 1'b0; else irq_pending = 1'b1;
      step();
      restore(0);
    end

    // R5 and R7: halt from both values of bit 0, ignores all but NMI
    for (int m = 2; m < 4; m++) begin
      enter(m);
      wdint_n = 1'b0; irq_pending = 1'b1; periph_wake_n = '0; wake_mask = '1;
      for (int k = 0; k < 4; k++) begin step(); check_sleep(2, "R7 halt ignores"); end
      wdint_n = 1'b1; irq_pending = 1'b0; periph_wake_n = '1;
      nmi_n = 1'b0;
      step();
      restore(2);
    end

    // R8: watchdog wakes standby at once even with an empty mask
    wake_mask = '0;
    enter(1);
    step(); check_sleep(1, "R8 waiting");
    wdint_n = 1'b0;
    step();
    restore(1);

    // R9 / R10 sweep over lines and qualification lengths
    for (int qi = 0; qi < 4; qi++) begin
      int q;
      q = (qi == 0) ? 0 : (qi == 1) ? 1 : (qi == 2) ? 4 : 63;
      qual_len = QW'(q);
      for (int idx = 0; idx <= NP; idx++) begin
        // unselected line ignored
        wake_mask = '1;
        wake_mask[idx] = 1'b0;
        enter(1);
        drive_line(idx, 1'b0);
        for (int k = 0; k < q + 4; k++) begin step(); check_sleep(1, "R9 unselected ignored"); end
        drive_line(idx, 1'b1);
        wdint_n = 1'b0; step(); restore(1);

        // short hold discarded
        wake_mask = '0;
        wake_mask[idx] = 1'b1;
        enter(1);
        drive_line(idx, 1'b0);
        for (int k = 0; k < q + 1; k++) begin step(); check_sleep(1, "R10 short hold"); end
        drive_line(idx, 1'b1);
        for (int k = 0; k < 3; k++) begin step(); check_sleep(1, "R10 stays standby"); end

        // full hold accepted after a restart
        drive_line(idx, 1'b0);
        for (int k = 0; k < q + 1; k++) begin step(); check_sleep(1, "R9 counting"); end
        step();
        restore(1);
      end
    end

    // R1: reset from standby and from halt
    wake_mask = '0;
    enter(1);
    do_reset();
    enter(3);
    do_reset();
    step(); check(1, 1, 1, 0, "R1 after reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule